// File: doc/BRIEF.md
# Multiplexed Bus Master Cycle Sequencer

This block runs one transfer at a time on a 16-bit multiplexed address/data bus with a 24-bit address space, acting as the bus master. The top eight address bits go out on their own lines. The low sixteen bits are placed on the shared data lines during a two-cycle address phase. A data phase follows and lasts until the addressed device returns ready.

A client issues a request by giving the address, the direction, the size (byte or word), a flag that marks the data as belonging to the FIFO path, and the write data. The block reports completion with a one-cycle done pulse. For reads, the captured word is presented at the same time. Three configuration inputs are sampled when a request is accepted:

- The address strobe style: a latch enable, or a short strobe whose rising edge captures the address.
- The byte-lane signalling: a two-bit lane mask, or a byte flag that is read together with address bit 0.
- Byte swapping, which applies only to data on the FIFO path.

While the block does not own the bus, its upper address, strobe and lane outputs are released to high impedance.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, and `bus_own`, `done`, `err` and `dal_oe` are all 0.
- R2: An accepted request gives two address cycles. In both, `bus_own`=1, `dal_oe`=1, `addr_hi` shows address bits 23..16 and `dal_out` shows address bits 15..0. These start in the cycle after the accepting clock edge.
- R3: Latch style (`cfg_strb_pulse`=0): `strb` is 1 in the first address cycle and 0 in the second address cycle and in every data cycle.
- R4: Strobe style (`cfg_strb_pulse`=1): `strb` is 0 in the first address cycle only. It is 1 in the second address cycle and in every data cycle.
- R5: Mask mode (`cfg_lane_flag`=0) encodes the lane as `lane[1:0]`:
  - 00 for a word.
  - 01 for the upper byte (byte request with address bit 0 = 1).
  - 10 for the lower byte (byte request with address bit 0 = 0).
- R6: Flag mode (`cfg_lane_flag`=1): `lane[0]` carries the byte flag (1 = byte) and `lane[1]` is 0. Address bit 0 reaches the device on `dal_out[0]` during the address phase.
- R7: In flag mode, a word request with address bit 0 = 1 is illegal. It raises `err` for one cycle, the cycle after acceptance, and `bus_own` stays 0. In mask mode the same request is legal.
- R8: The data phase repeats until `rdy` is sampled 1. `done` is then 1 for exactly one cycle, the cycle after that edge.
  - A write drives the data on `dal_out` with `dal_oe`=1.
  - A read holds `dal_oe`=0 and returns the captured `dal_in` on `rdata` during `done`.
- R9: When `cfg_swap`=1 and `req_fifo`=1, the two data bytes are exchanged in both directions. Data bits 15..8 appear on bits 7..0, and bits 7..0 appear on bits 15..8. Requests with `req_fifo`=0 are never swapped.
- R10: The request fields and configuration are captured when a request is accepted. Changes to them during the transfer have no effect. `bus_own` returns to 0 in the `done` cycle.
- R11: `req_ready` is 1 in the `done` cycle. A request presented in that cycle is accepted with no idle cycle between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 24 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte transfer, 0 = word |
| req_fifo | input | 1 | Data belongs to the FIFO path |
| req_wdata | input | 16 | Write data |
| cfg_lane_flag | input | 1 | 0 = lane mask, 1 = byte flag with address bit 0 |
| cfg_strb_pulse | input | 1 | 0 = latch-enable strobe, 1 = pulsed strobe |
| cfg_swap | input | 1 | Byte swap for FIFO-path data |
| rdy | input | 1 | Device ready, ends the data phase |
| dal_in | input | 16 | Data lines as read from the bus |
| req_ready | output | 1 | Block idle, a request may be accepted |
| bus_own | output | 1 | Block is driving the bus as master |
| addr_hi | output | 8 | Upper address lines, high impedance when not owner |
| strb | output | 1 | Address strobe, high impedance when not owner |
| lane | output | 2 | Byte-lane signalling, high impedance when not owner |
| dal_out | output | 16 | Value driven onto the shared data lines |
| dal_oe | output | 1 | Data line output enable |
| rd_dir | output | 1 | Current transfer is a read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-request pulse |
| rdata | output | 16 | Read data, valid with `done` |

## Verification
Two events can fall in the same cycle: the done pulse that ends one transfer, and the acceptance of the next request. The bench issues every transfer straight after the previous one, so each new request is already waiting during the done cycle.

A scoreboard pairs each done or error pulse with the item queued by the driver. In that same cycle it checks that `req_ready` is high. The driver then checks that the next address phase starts exactly one edge later, with the address and strobe of the new request.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADR_A = 2'd1,
        PH_ADR_B = 2'd2,
        PH_DATA  = 2'd3
    } phase_e;

    localparam logic [1:0] LANE_WORD  = 2'b00;
    localparam logic [1:0] LANE_UPPER = 2'b01;
    localparam logic [1:0] LANE_LOWER = 2'b10;

endpackage

// File: rtl/mbus_lane_enc.sv
module mbus_lane_enc (
    input  logic       flag_mode,
    input  logic       is_byte,
    input  logic       a0,
    output logic [1:0] lane,
    output logic       illegal
);
    import mbus_pkg::*;

    always_comb begin
        illegal = 1'b0;
        if (flag_mode) begin
            lane    = {1'b0, is_byte};
            illegal = !is_byte && a0;
        end else if (!is_byte) begin
            lane = LANE_WORD;
        end else if (a0) begin
            lane = LANE_UPPER;
        end else begin
            lane = LANE_LOWER;
        end
    end

endmodule

// File: rtl/mbus_byte_swap.sv
module mbus_byte_swap #(
    parameter int DW = 16
) (
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign dout[i*8 +: 8] = en ? din[(NB-1-i)*8 +: 8] : din[i*8 +: 8];
    end

endmodule

// File: rtl/mbus_strobe_gen.sv
module mbus_strobe_gen (
    input  mbus_pkg::phase_e ph,
    input  logic             pulse_mode,
    output logic             strb
);
    import mbus_pkg::*;

    // latch style: high in first address cycle, low afterwards
    // pulse style: low in first address cycle, rising edge opens second
    always_comb begin
        if (pulse_mode) strb = (ph != PH_ADR_A);
        else            strb = (ph == PH_ADR_A);
    end

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq #(
    parameter  int AW = mbus_pkg::ADDR_W,
    parameter  int DW = mbus_pkg::DATA_W,
    localparam int HW = AW - DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_byte,
    input  logic          req_fifo,
    input  logic [DW-1:0] req_wdata,
    input  logic          cfg_lane_flag,
    input  logic          cfg_strb_pulse,
    input  logic          cfg_swap,
    input  logic          rdy,
    input  logic [DW-1:0] dal_in,
    output logic          req_ready,
    output logic          bus_own,
    output logic [HW-1:0] addr_hi,
    output logic          strb,
    output logic [1:0]    lane,
    output logic [DW-1:0] dal_out,
    output logic          dal_oe,
    output logic          rd_dir,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata
);
    import mbus_pkg::*;

    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          wr;
        logic [1:0]    lane;
        logic          pulse;
        logic          swap;
        logic          done;
        logic          err;
        logic [DW-1:0] rdata;
    } seq_s;

    seq_s          seq_d, seq_q;
    logic [1:0]    lane_enc;
    logic          lane_bad;
    logic [DW-1:0] wdata_sw;
    logic [DW-1:0] rdata_sw;
    logic          strb_val;
    logic          owned;

    mbus_lane_enc u_lane (
        .flag_mode (cfg_lane_flag),
        .is_byte   (req_byte),
        .a0        (req_addr[0]),
        .lane      (lane_enc),
        .illegal   (lane_bad)
    );

    mbus_byte_swap #(.DW(DW)) u_swap_wr (
        .en   (seq_q.swap),
        .din  (seq_q.wdata),
        .dout (wdata_sw)
    );

    mbus_byte_swap #(.DW(DW)) u_swap_rd (
        .en   (seq_q.swap),
        .din  (dal_in),
        .dout (rdata_sw)
    );

    mbus_strobe_gen u_strb (
        .ph         (seq_q.ph),
        .pulse_mode (seq_q.pulse),
        .strb       (strb_val)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    if (lane_bad) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.ph    = PH_ADR_A;
                        seq_d.addr  = req_addr;
                        seq_d.wdata = req_wdata;
                        seq_d.wr    = req_write;
                        seq_d.lane  = lane_enc;
                        seq_d.pulse = cfg_strb_pulse;
                        seq_d.swap  = cfg_swap && req_fifo;
                    end
                end
            end
            PH_ADR_A: seq_d.ph = PH_ADR_B;
            PH_ADR_B: seq_d.ph = PH_DATA;
            PH_DATA: begin
                if (rdy) begin
                    seq_d.ph   = PH_IDLE;
                    seq_d.done = 1'b1;
                    if (!seq_q.wr) seq_d.rdata = rdata_sw;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign owned     = (seq_q.ph != PH_IDLE);
    assign req_ready = !owned;
    assign bus_own   = owned;
    assign rd_dir    = owned && !seq_q.wr;
    assign done      = seq_q.done;
    assign err       = seq_q.err;
    assign rdata     = seq_q.rdata;

    always_comb begin
        dal_oe  = 1'b0;
        dal_out = '0;
        if (seq_q.ph == PH_ADR_A || seq_q.ph == PH_ADR_B) begin
            dal_oe  = 1'b1;
            dal_out = seq_q.addr[DW-1:0];
        end else if (seq_q.ph == PH_DATA && seq_q.wr) begin
            dal_oe  = 1'b1;
            dal_out = wdata_sw;
        end
    end

    assign addr_hi = owned ? seq_q.addr[AW-1:DW] : 'z;
    assign strb    = owned ? strb_val : 1'bz;
    assign lane    = owned ? seq_q.lane : 2'bzz;

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic err,
    input logic bus_own,
    input logic req_ready,
    input logic dal_oe
);
    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a rejected request never takes the bus
    p_err_noown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!bus_own && req_ready));

    // R7: error and completion never coincide
    p_done_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R11: ready for a new request in the completion cycle
    p_done_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R10: bus released when done
    p_done_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_own);

    // R2: taking the bus starts with the address driven
    p_own_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> dal_oe);

endmodule

bind mbus_cycle_seq mbus_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .err       (err),
    .bus_own   (bus_own),
    .req_ready (req_ready),
    .dal_oe    (dal_oe)
);

// File: tb/sim_mbus_cycle_seq.sv
`timescale 1ns/1ps
module sim_mbus_cycle_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_byte = 1'b0;
    logic        req_fifo = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        cfg_lane_flag = 1'b0;
    logic        cfg_strb_pulse = 1'b0;
    logic        cfg_swap = 1'b0;
    logic        rdy = 1'b0;
    logic [15:0] dal_in = '0;
    logic        req_ready, bus_own, strb, dal_oe, rd_dir, done, err;
    logic [7:0]  addr_hi;
    logic [1:0]  lane;
    logic [15:0] dal_out, rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        is_err;
        logic        chk_rd;
        logic [15:0] rd;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    mbus_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_byte(req_byte), .req_fifo(req_fifo),
        .req_wdata(req_wdata), .cfg_lane_flag(cfg_lane_flag),
        .cfg_strb_pulse(cfg_strb_pulse), .cfg_swap(cfg_swap), .rdy(rdy),
        .dal_in(dal_in), .req_ready(req_ready), .bus_own(bus_own),
        .addr_hi(addr_hi), .strb(strb), .lane(lane), .dal_out(dal_out),
        .dal_oe(dal_oe), .rd_dir(rd_dir), .done(done), .err(err), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] swp16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    // monitor: pairs done/err pulses with queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (done || err)) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 unexpected completion", {22'd0, done, err}, 24'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(err == e.is_err, "R7 err vs done", {23'd0, err}, {23'd0, e.is_err});
                    chk(req_ready == 1'b1, "R11 ready in completion cycle", {23'd0, req_ready}, 24'd1);
                    if (e.chk_rd)
                        chk(rdata == e.rd, "R8/R9 read data", {8'd0, rdata}, {8'd0, e.rd});
                end
            end
        end
    end

    task automatic xfer(input logic [23:0] a, input logic wr, input logic byt, input logic fifo,
                        input logic [15:0] wd, input logic [15:0] rd, input int waits,
                        input logic flag_m, input logic pulse_m, input logic sw_cfg);
        logic illegal;
        logic sw;
        logic [1:0] exp_lane;
        logic [15:0] exp_wd;
        exp_t e;
        illegal = flag_m && !byt && a[0];
        sw = sw_cfg && fifo;
        exp_wd = sw ? swp16(wd) : wd;
        if (flag_m)      exp_lane = {1'b0, byt};
        else if (!byt)   exp_lane = 2'b00;
        else if (a[0])   exp_lane = 2'b01;
        else             exp_lane = 2'b10;
        e.is_err = illegal;
        e.chk_rd = !illegal && !wr;
        e.rd = sw ? swp16(rd) : rd;
        sb.push_back(e);
        req_addr = a; req_write = wr; req_byte = byt; req_fifo = fifo; req_wdata = wd;
        cfg_lane_flag = flag_m; cfg_strb_pulse = pulse_m; cfg_swap = sw_cfg;
        req_valid = 1'b1;
        @(negedge clk);
        // R10: disturb everything after acceptance
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
        req_byte = ~byt; req_fifo = ~fifo;
        cfg_lane_flag = ~flag_m; cfg_strb_pulse = ~pulse_m; cfg_swap = ~sw_cfg;
        if (illegal) begin
            chk(!bus_own, "R7 no bus cycle on illegal", {23'd0, bus_own}, 24'd0);
            return;
        end
        // first address cycle
        chk(bus_own, "R2 owner", {23'd0, bus_own}, 24'd1);
        chk(addr_hi == a[23:16], "R2 addr_hi", {16'd0, addr_hi}, {16'd0, a[23:16]});
        chk(dal_oe && dal_out == a[15:0], "R2 dal addr", {8'd0, dal_out}, {8'd0, a[15:0]});
        chk(strb == !pulse_m, pulse_m ? "R4 strobe A" : "R3 strobe A", {23'd0, strb}, {23'd0, !pulse_m});
        chk(lane == exp_lane, flag_m ? "R6 lane flag" : "R5 lane mask", {22'd0, lane}, {22'd0, exp_lane});
        @(negedge clk);
        // second address cycle
        chk(dal_oe && dal_out == a[15:0], "R2 dal addr B", {8'd0, dal_out}, {8'd0, a[15:0]});
        chk(strb == pulse_m, pulse_m ? "R4 strobe B" : "R3 strobe B", {23'd0, strb}, {23'd0, pulse_m});
        @(negedge clk);
        for (int w = 0; w <= waits; w++) begin
            chk(bus_own, "R8 held in data phase", {23'd0, bus_own}, 24'd1);
            chk(strb == pulse_m, pulse_m ? "R4 strobe D" : "R3 strobe D", {23'd0, strb}, {23'd0, pulse_m});
            chk(dal_oe == wr, "R8 dal_oe direction", {23'd0, dal_oe}, {23'd0, wr});
            chk(rd_dir == !wr, "R8 rd_dir", {23'd0, rd_dir}, {23'd0, !wr});
            if (wr)
                chk(dal_out == exp_wd, "R8/R9 write data", {8'd0, dal_out}, {8'd0, exp_wd});
            if (w == waits) begin
                rdy = 1'b1;
                dal_in = rd;
            end
            @(negedge clk);
        end
        rdy = 1'b0;
        dal_in = 16'hDEAD;
        chk(done == 1'b1, "R8 done after ready", {23'd0, done}, 24'd1);
        chk(!bus_own, "R10 bus released", {23'd0, bus_own}, 24'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !bus_own && !done && !err && !dal_oe, "R1 reset state",
            {19'd0, req_ready, bus_own, done, err, dal_oe}, 24'h10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_own, "R1 idle after reset", {22'd0, req_ready, bus_own}, 24'h2);
        // all transfers back to back (R11)
        xfer(24'h123456, 1, 0, 0, 16'hA1B2, 16'h0000, 0, 0, 0, 0); // R5 word, R3
        xfer(24'h9A3C40, 0, 1, 0, 16'h0000, 16'h3C4D, 2, 0, 1, 0); // R5 lower, R4, R8 waits
        xfer(24'h00FF11, 1, 1, 0, 16'h5566, 16'h0000, 1, 0, 0, 0); // R5 upper
        xfer(24'h7E0001, 0, 1, 0, 16'h0000, 16'h8899, 0, 1, 1, 0); // R6 byte flag
        xfer(24'h440000, 1, 0, 0, 16'hCAFE, 16'h0000, 0, 1, 0, 0); // R6 word flag
        xfer(24'h440001, 1, 0, 0, 16'hCAFE, 16'h0000, 0, 1, 0, 0); // R7 illegal
        xfer(24'h440001, 0, 0, 0, 16'h0000, 16'h1357, 0, 0, 1, 0); // R7 legal in mask mode
        xfer(24'h200010, 1, 0, 1, 16'h1234, 16'h0000, 1, 0, 0, 1); // R9 swapped write
        xfer(24'h200012, 0, 0, 1, 16'h0000, 16'hABCD, 0, 0, 1, 1); // R9 swapped read
        xfer(24'h200014, 0, 0, 0, 16'h0000, 16'hABCD, 0, 0, 0, 1); // R9 non-FIFO unswapped
        xfer(24'h200016, 1, 0, 0, 16'h1234, 16'h0000, 0, 1, 1, 1); // R9 non-FIFO write
        @(negedge clk);
        chk(sb.size() == 0, "R8 all completions seen", sb.size(), 24'd0);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule